// File: doc/BRIEF.md
# Power Mode Clock Controller

This block keeps the power state of a small processor core and turns one master clock into clock-enable strobes for the CPU and for its peripherals. Everything runs in the master-clock domain. A reduced rate is made with enable strobes, not with a second clock. Software-side control comes in as a slow-mode enable level, a two-bit rate select and single-cycle requests for wait, active halt and halt. An interrupt line wakes the core from any of the sleeping states.

The state machine has six states. From most to least power they are Run, Slow, Wait, Slow Wait, Active Halt and Halt. A wait request taken while the slow rate is in force leads to a separate Slow Wait state, in which the peripherals keep the divided rate. In every sleeping state the CPU strobe is held low. Only Halt drops the oscillator-run output. The rate select is sampled once per divided period, so a change in the middle of a period cannot shorten the gap between two strobes.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, the mode code is 0 (Run), both enables are high and the oscillator-run output is high.
- R2: In Run with no request pending, a high slow enable moves to Slow (code 1) at the next edge. A low slow enable in Slow returns to Run (code 0) at the next edge.
- R3: In Slow, select 00, 01, 10 and 11 give one CPU strobe every 2, 4, 8 and 16 cycles. The first strobe comes in the N-th cycle after entering Slow, where N is the period. The peripheral strobe is identical to the CPU strobe.
- R4: A new select value takes effect only after the strobe that ends the current period. Strobes stay on the old spacing until that strobe, and follow the new spacing from then on.
- R5: A wait request in Slow enters Slow Wait (code 3). A wait request in Run enters Wait (code 2).
- R6: In Wait the CPU strobe is low and the peripheral strobe is high in every cycle. In Slow Wait the CPU strobe is low and the peripheral strobe keeps the divided rate.
- R7: An active-halt request in Run or Slow enters code 4, with both strobes low and oscillator-run high. A halt request enters code 5, with oscillator-run also low.
- R8: When several requests arrive together, halt wins over active halt, and active halt wins over wait. Requests have no effect in Wait, Slow Wait, Active Halt or Halt.
- R9: An interrupt in codes 2 to 5 moves at the next edge to Slow if the slow enable is high, otherwise to Run. An interrupt in Run or Slow has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_en | input | 1 | Slow-mode enable level |
| slow_sel | input | SEL_W | Divider select: period is 2^(slow_sel+1) cycles |
| wait_req | input | 1 | Wait request pulse |
| ahalt_req | input | 1 | Active-halt request pulse |
| halt_req | input | 1 | Halt request pulse |
| irq | input | 1 | Wake-up interrupt |
| cpu_ce | output | 1 | CPU clock-enable strobe |
| per_ce | output | 1 | Peripheral clock-enable strobe |
| osc_run | output | 1 | Oscillator keep-running signal |
| mode | output | 3 | Current mode code (0 Run, 1 Slow, 2 Wait, 3 Slow Wait, 4 Active Halt, 5 Halt) |

## Verification
A wrong state register shows on the mode code at the first edge after the stimulus. It also shows on the enable pattern in the same cycle. A stuck oscillator-run level or a CPU strobe during sleep is visible at once. A wrong divider count or a wrong select value appears as a misplaced strobe within at most sixteen cycles. The bench therefore checks the strobes in every cycle of each slow window, so it catches the first misplaced pulse.

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_en,
  input  logic [SEL_W-1:0] slow_sel,
  input  logic             wait_req,
  input  logic             ahalt_req,
  input  logic             halt_req,
  input  logic             irq,
  output logic             cpu_ce,
  output logic             per_ce,
  output logic             osc_run,
  output logic [2:0]       mode
);
  localparam int CNT_W = 1 << SEL_W;

  typedef enum logic [2:0] {
    M_RUN = 3'd0, M_SLOW = 3'd1, M_WAIT = 3'd2,
    M_SWAIT = 3'd3, M_AHALT = 3'd4, M_HALT = 3'd5
  } mode_t;

  mode_t            st, nx;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] last;
  logic             in_slow, tick, asleep;

  assign in_slow = (st == M_SLOW) || (st == M_SWAIT);
  assign asleep  = (st == M_WAIT) || (st == M_SWAIT) || (st == M_AHALT) || (st == M_HALT);
  assign period  = (CNT_W+1)'(1) << ({1'b0, sel_q} + 1'b1);
  assign last    = CNT_W'(period - 1'b1);
  assign tick    = in_slow && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_q <= '0;
    end else if (!in_slow) begin
      cnt   <= '0;
      sel_q <= slow_sel;
    end else if (tick) begin
      cnt   <= '0;
      sel_q <= slow_sel;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_comb begin
    nx = st;
    unique case (st)
      M_RUN, M_SLOW: begin
        if (halt_req)       nx = M_HALT;
        else if (ahalt_req) nx = M_AHALT;
        else if (wait_req)  nx = (st == M_SLOW) ? M_SWAIT : M_WAIT;
        else                nx = slow_en ? M_SLOW : M_RUN;
      end
      M_WAIT, M_SWAIT, M_AHALT, M_HALT:
        if (irq) nx = slow_en ? M_SLOW : M_RUN;
      default: nx = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= M_RUN;
    else        st <= nx;
  end

  assign cpu_ce  = (st == M_RUN) || (st == M_SLOW && tick);
  assign per_ce  = (st == M_RUN) || (st == M_WAIT) || tick;
  assign osc_run = (st != M_HALT);
  assign mode    = st;

  p_reset_run_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mode == 3'd0 && cpu_ce && per_ce && osc_run));

  p_ce_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_SLOW && cpu_ce) |=> (st != M_SLOW || !cpu_ce));

  p_slow_wait_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_SLOW && wait_req && !halt_req && !ahalt_req) |=> (mode == 3'd3 && !cpu_ce));

  p_halt_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == M_RUN || st == M_SLOW) && halt_req) |=> (mode == 3'd5 && !osc_run && !per_ce));

  p_irq_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && irq) |=> (mode == ($past(slow_en) ? 3'd1 : 3'd0)));

  p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !irq) |=> $stable(mode));
endmodule

// File: tb/tb_pwr_clk_ctrl.sv
module tb_pwr_clk_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_en = 1'b0;
  logic [1:0] slow_sel = 2'd0;
  logic       wait_req = 1'b0, ahalt_req = 1'b0, halt_req = 1'b0, irq = 1'b0;
  logic       cpu_ce, per_ce, osc_run;
  logic [2:0] mode;
  int         n_chk = 0, n_bad = 0;

  pwr_clk_ctrl #(.SEL_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .slow_sel(slow_sel),
    .wait_req(wait_req), .ahalt_req(ahalt_req), .halt_req(halt_req), .irq(irq),
    .cpu_ce(cpu_ce), .per_ce(per_ce), .osc_run(osc_run), .mode(mode)
  );

  always #4 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input int m, input int c, input int p, input int o);
    chk(req, int'(mode), m);
    chk(req, int'(cpu_ce), c);
    chk(req, int'(per_ce), p);
    chk(req, int'(osc_run), o);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    outs("R1", 0, 1, 1, 1);
    step(); step();
    rst_n = 1'b1;
    step();
    outs("R1", 0, 1, 1, 1);

    // R3 sweep of all selects; R2 entry and exit
    for (int s = 0; s < 4; s++) begin
      int per;
      per = 2 << s;
      slow_sel = 2'(s);
      slow_en = 1'b1;
      for (int k = 1; k <= 40; k++) begin
        step();
        chk("R2", int'(mode), 1);
        chk("R3 cpu", int'(cpu_ce), (k % per == 0) ? 1 : 0);
        chk("R3 per", int'(per_ce), (k % per == 0) ? 1 : 0);
      end
      slow_en = 1'b0;
      step();
      outs("R2", 0, 1, 1, 1);
    end

    // R4 select change mid-period
    slow_sel = 2'd3;
    slow_en = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      step();
      chk("R4", int'(cpu_ce), (k <= 16) ? ((k == 16) ? 1 : 0) : (((k - 16) % 2 == 0) ? 1 : 0));
      if (k == 5) slow_sel = 2'd0;
    end

    // R5/R6 slow wait from slow at divide-by-4
    slow_sel = 2'd1;
    step(); step(); step();
    wait_req = 1'b1;
    step();
    wait_req = 1'b0;
    chk("R5", int'(mode), 3);
    begin
      int np, nc;
      np = 0; nc = 0;
      for (int k = 0; k < 32; k++) begin
        np += int'(per_ce);
        nc += int'(cpu_ce);
        step();
      end
      chk("R6 per", np, 8);
      chk("R6 cpu", nc, 0);
    end
    irq = 1'b1;
    step();
    irq = 1'b0;
    chk("R9", int'(mode), 1);

    // R7 active halt from slow, wake to run
    ahalt_req = 1'b1;
    step();
    ahalt_req = 1'b0;
    outs("R7", 4, 0, 0, 1);
    slow_en = 1'b0;
    step();
    outs("R7", 4, 0, 0, 1);
    irq = 1'b1;
    step();
    irq = 1'b0;
    outs("R9", 0, 1, 1, 1);

    // R9 interrupt in Run has no effect
    irq = 1'b1;
    step();
    irq = 1'b0;
    outs("R9", 0, 1, 1, 1);

    // R5/R6 wait from run, R8 requests ignored
    wait_req = 1'b1;
    step();
    wait_req = 1'b0;
    for (int k = 0; k < 10; k++) begin
      outs("R6", 2, 0, 1, 1);
      halt_req = (k == 3);
      ahalt_req = (k == 6);
      step();
    end
    halt_req = 1'b0;
    ahalt_req = 1'b0;
    outs("R8", 2, 0, 1, 1);
    irq = 1'b1;
    step();
    irq = 1'b0;
    outs("R9", 0, 1, 1, 1);

    // R8 priority, R7 halt, R9 wake to slow
    halt_req = 1'b1; ahalt_req = 1'b1; wait_req = 1'b1;
    step();
    halt_req = 1'b0; ahalt_req = 1'b0; wait_req = 1'b0;
    outs("R8", 5, 0, 0, 0);
    step();
    outs("R7", 5, 0, 0, 0);
    slow_en = 1'b1;
    irq = 1'b1;
    step();
    irq = 1'b0;
    chk("R9", int'(mode), 1);
    slow_en = 1'b0;
    step();
    ahalt_req = 1'b1; wait_req = 1'b1;
    step();
    ahalt_req = 1'b0; wait_req = 1'b0;
    outs("R8", 4, 0, 0, 1);
    irq = 1'b1;
    step();
    irq = 1'b0;

    // R1 reset in the middle of slow mode
    slow_en = 1'b1;
    step(); step(); step();
    chk("R2", int'(mode), 1);
    slow_en = 1'b0;
    rst_n = 1'b0;
    #1;
    outs("R1", 0, 1, 1, 1);
    step();
    rst_n = 1'b1;
    step();
    outs("R1", 0, 1, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule